// File: doc/BRIEF.md
# Sorter-Feedback Stochastic Neuron

This block is one neuron of a stochastic-computing network. It merges the weighted sum and a clipped-linear activation, and it holds no binary accumulator. Each accepted clock it takes one bit from each of M bipolar input streams and one bit from each of M matching weight streams. It multiplies each pair with an XNOR and emits one bit of the output stream. The running surplus of ones is carried from cycle to cycle as a short sorted vector of bits, not as a count.

The product column is sorted in descending order, so ones come first. A merger then joins it with the sorted feedback vector carried over from the previous column. One fixed rank of the merged vector is the output bit. A fixed window of the merged vector is registered as the next feedback. Choosing the rank subtracts the activation threshold. Choosing the window clips the surplus at zero and at its width.

When M is even, the block adds an internal alternating 0/1 stream as an extra input, so the sorted width K is always odd. K equals M when M is odd and M+1 when M is even.

Input columns arrive with `in_valid` and the block never applies back-pressure: every cycle with `in_valid` high consumes a column. The output is a registered stream qualified by `out_valid`, which the consumer must always take. `start` is a plain control pin that begins a new stream.

Top module: `stoch_sort_neuron`

## Requirements
- R1: Each accepted column forms M product bits, where product i is 1 exactly when `in_bits[i]` equals `wt_bits[i]` (XNOR).
- R2: Let c be the number of ones in the K-bit column plus the number of ones in the feedback vector in use. The output bit registered for that column is 1 exactly when c > (K-1)/2.
- R3: After an accepted column, the feedback holds min(K, max(0, c-(K+1)/2)) ones. They are stored as a thermometer code, with the ones in the lowest bit positions.
- R4: `start` high without `in_valid` clears the feedback and the alternating stream. `start` together with `in_valid` processes that column as the first column of a new stream, using zero feedback and an alternating bit of 0.
- R5: For even M, the extra column bit is 0 on the first column after reset or start. It inverts on each later accepted column. For odd M, there is no extra bit.
- R6: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. `out_bit` keeps its value when no column was accepted.
- R7: A cycle with neither `in_valid` nor `start` leaves the feedback and the alternating stream unchanged, so the stream resumes exactly where it paused.
- R8: Asynchronous active-low reset sets `out_valid` and `out_bit` to 0 and clears the feedback and the alternating stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous begin-of-stream; clears the carried surplus |
| in_valid | input | 1 | Column qualifier for in_bits and wt_bits |
| in_bits | input | M | One bit of each input stream |
| wt_bits | input | M | One bit of each weight stream |
| out_valid | output | 1 | Output bit qualifier, one cycle after in_valid |
| out_bit | output | 1 | Registered output stream bit |

## Verification
Two functions can act in the same cycle: clearing the carried surplus on `start`, and consuming a column with `in_valid`. The bench drives `start` together with `in_valid` in the middle of long streams, when the feedback and the alternating bit are nonzero. It also drives `start` alone and plain idle gaps. A behavioural model counts ones to decide each output bit. It compares every cycle against an odd-width and an even-width instance, so a collision that used stale feedback, or that skipped the column, shows up as a mismatched output bit in that cycle or later.

// File: rtl/sn_pkg.sv
package sn_pkg;

  // Sorted width: odd M is kept, even M gains one padding input.
  function automatic int sn_eff_width(input int m);
    return (m % 2 == 1) ? m : m + 1;
  endfunction

  // Smallest power of two not below n.
  function automatic int sn_pow2_ceil(input int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

  // Two-bit compare-exchange: {larger, smaller}.
  function automatic logic [1:0] sn_ce(input logic a, input logic b);
    return {a | b, a & b};
  endfunction

endpackage

// File: rtl/sn_col_sorter.sv
module sn_col_sorter
  import sn_pkg::*;
#(
  parameter int N = 9
) (
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  // Odd-even transposition network: N stages of compare-exchange.
  // Index 0 receives the largest bit (descending order).
  always_comb begin
    logic [N-1:0] v;
    v = d;
    for (int s = 0; s < N; s++) begin
      for (int i = s % 2; i + 1 < N; i += 2) begin
        {v[i], v[i+1]} = sn_ce(v[i], v[i+1]);
      end
    end
    q = v;
  end
endmodule

// File: rtl/sn_bitonic_merger.sv
module sn_bitonic_merger
  import sn_pkg::*;
#(
  parameter int K     = 9,
  parameter int RANK  = 4,
  parameter int WSTART = 5
) (
  input  logic [K-1:0] a_desc,
  input  logic [K-1:0] b_desc,
  output logic         rank_bit,
  output logic [K-1:0] window
);
  localparam int P    = sn_pow2_ceil(2 * K);
  localparam int LOGP = $clog2(P);

  // a descending, zero padding, then b reversed: a valley-shaped
  // bitonic sequence of P bits, merged by half-cleaner stages.
  always_comb begin
    logic [P-1:0] v;
    int h;
    v = '0;
    for (int i = 0; i < K; i++) v[i] = a_desc[i];
    for (int j = 0; j < K; j++) v[P-1-j] = b_desc[j];
    for (int s = 0; s < LOGP; s++) begin
      h = P >> (s + 1);
      for (int i = 0; i < P; i++) begin
        if ((i % (2 * h)) < h) begin
          {v[i], v[i+h]} = sn_ce(v[i], v[i+h]);
        end
      end
    end
    rank_bit = v[RANK];
    window   = v[WSTART +: K];
  end
endmodule

// File: rtl/sn_alt_source.sv
module sn_alt_source (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  output logic alt_bit
);
  logic alt_q;

  // A start column always sees 0; later columns alternate.
  assign alt_bit = start ? 1'b0 : alt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q <= 1'b0;
    end else if (in_valid) begin
      alt_q <= ~alt_bit;
    end else if (start) begin
      alt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stoch_sort_neuron.sv
module stoch_sort_neuron
  import sn_pkg::*;
#(
  parameter int M = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         in_valid,
  input  logic [M-1:0] in_bits,
  input  logic [M-1:0] wt_bits,
  output logic         out_valid,
  output logic         out_bit
);
  localparam int K   = sn_eff_width(M);
  localparam int MID = (K - 1) / 2;
  localparam int W0  = (K + 1) / 2;

  logic [M-1:0] prod;
  logic [K-1:0] col;
  logic [K-1:0] col_sorted;
  logic [K-1:0] fb_q;
  logic [K-1:0] fb_eff;
  logic [K-1:0] fb_nxt;
  logic         res;

  // Bipolar multiply: XNOR per input pair.
  assign prod = ~(in_bits ^ wt_bits);

  generate
    if (K > M) begin : g_pad
      logic alt;
      sn_alt_source u_alt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .alt_bit  (alt)
      );
      assign col = {alt, prod};
    end else begin : g_nopad
      assign col = prod;
    end
  endgenerate

  sn_col_sorter #(.N(K)) u_sort (
    .d (col),
    .q (col_sorted)
  );

  // A start column begins from an empty surplus.
  assign fb_eff = start ? '0 : fb_q;

  sn_bitonic_merger #(.K(K), .RANK(MID), .WSTART(W0)) u_merge (
    .a_desc   (col_sorted),
    .b_desc   (fb_eff),
    .rank_bit (res),
    .window   (fb_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_bit <= res;
        fb_q    <= fb_nxt;
      end else if (start) begin
        fb_q <= '0;
      end
    end
  end
endmodule

// File: rtl/stoch_sort_neuron_chk.sv
module stoch_sort_neuron_chk
  import sn_pkg::*;
#(
  parameter int M = 9
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      in_valid,
  input logic [M-1:0]              in_bits,
  input logic [M-1:0]              wt_bits,
  input logic                      out_valid,
  input logic                      out_bit,
  input logic [sn_eff_width(M)-1:0] fb_q
);
  localparam int K = sn_eff_width(M);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_bit)); // R6
  AST_FB_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_q & (fb_q + K'(1))) == '0); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start && !in_valid |=> fb_q == '0); // R4
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !in_valid |=> $stable(fb_q)); // R7
  AST_ALL_AGREE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ((in_bits ^ wt_bits) == '0) |=> out_bit); // R2
  AST_FRESH_DISAGREE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && start && (&(in_bits ^ wt_bits)) |=> !out_bit); // R4
endmodule

bind stoch_sort_neuron stoch_sort_neuron_chk #(.M(M)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_valid  (in_valid),
  .in_bits   (in_bits),
  .wt_bits   (wt_bits),
  .out_valid (out_valid),
  .out_bit   (out_bit),
  .fb_q      (fb_q)
);

// File: tb/stoch_sort_neuron_test.sv
module stoch_sort_neuron_test;
  localparam int MO = 9;
  localparam int ME = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [MO-1:0] xo = '0, wo = '0;
  logic [ME-1:0] xe = '0, we = '0;
  logic ov_o, ob_o, ov_e, ob_e;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  bit done = 1'b0;

  // model state per instance
  int fbc_o = 0, fbc_e = 0;
  bit alt_o = 0, alt_e = 0;
  bit eo_o = 0, ev_o = 0, eo_e = 0, ev_e = 0;

  always #5 clk = ~clk;

  stoch_sort_neuron #(.M(MO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_bits(xo), .wt_bits(wo), .out_valid(ov_o), .out_bit(ob_o));

  stoch_sort_neuron #(.M(ME)) uut_even (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_bits(xe), .wt_bits(we), .out_valid(ov_e), .out_bit(ob_e));

  // Behavioural reference: counts ones, no sorting structure.
  function automatic void model(input int m, input bit st, input bit v,
                                input logic [15:0] x, input logic [15:0] w,
                                inout int fbc, inout bit alt,
                                inout bit eo, inout bit ev);
    int k, c, f, n;
    bit a;
    k = (m % 2 == 1) ? m : m + 1;
    if (v) begin
      f = st ? 0 : fbc;
      a = st ? 1'b0 : alt;
      c = f;
      for (int i = 0; i < m; i++) if (x[i] == w[i]) c++;   // R1
      if (k > m && a) c++;                                 // R5
      eo = (c > (k - 1) / 2);                              // R2
      n = c - (k + 1) / 2;
      if (n < 0) n = 0;
      if (n > k) n = k;
      fbc = n;                                             // R3
      alt = ~a;
      ev = 1'b1;
    end else begin
      ev = 1'b0;
      if (st) begin fbc = 0; alt = 1'b0; end               // R4
    end
  endfunction

  task automatic check(input string tag);
    checks += 4;
    if (ov_o !== ev_o) begin errs++; $display("FAIL %s odd out_valid act=%b exp=%b t=%0t", tag, ov_o, ev_o, $time); end
    if (ob_o !== eo_o) begin errs++; $display("FAIL %s odd out_bit act=%b exp=%b t=%0t", tag, ob_o, eo_o, $time); end
    if (ov_e !== ev_e) begin errs++; $display("FAIL %s even out_valid act=%b exp=%b t=%0t", tag, ov_e, ev_e, $time); end
    if (ob_e !== eo_e) begin errs++; $display("FAIL %s even out_bit act=%b exp=%b t=%0t", tag, ob_e, eo_e, $time); end
  endtask

  // One cycle: check the result of the previous cycle, then drive the next.
  task automatic step(input string tag, input bit st, input bit v,
                      input logic [MO-1:0] x9, input logic [MO-1:0] w9,
                      input logic [ME-1:0] x4, input logic [ME-1:0] w4);
    @(negedge clk);
    check(tag);
    start = st; in_valid = v; xo = x9; wo = w9; xe = x4; we = w4;
    model(MO, st, v, 16'(x9), 16'(w9), fbc_o, alt_o, eo_o, ev_o);
    model(ME, st, v, 16'(x4), 16'(w4), fbc_e, alt_e, eo_e, ev_e);
  endtask

  function automatic logic [MO-1:0] rbits(input int p16);
    logic [MO-1:0] r;
    for (int i = 0; i < MO; i++) r[i] = ($urandom_range(15) < p16);
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog expired act=%0d exp<=150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [MO-1:0] a9, b9;
    repeat (3) @(negedge clk);
    check("R8 reset");
    rst_n = 1'b1;
    // Plain random streams, mixed levels (R1 R2 R3 R5)
    for (int n = 0; n < 400; n++) begin
      a9 = rbits(8); b9 = rbits(4 + (n / 50));
      step("R1 R2 R3 R5 random", n == 0, 1'b1, a9, b9, a9[ME-1:0], b9[ME-1:0]);
    end
    // All products one, then all zero: saturation of feedback (R2 R3)
    for (int n = 0; n < 30; n++)
      step("R2 R3 all agree", 1'b0, 1'b1, '1, '1, '1, '1);
    for (int n = 0; n < 40; n++)
      step("R2 R3 all disagree", 1'b0, 1'b1, '1, '0, '1, '0);
    // Idle gaps with no start keep state (R6 R7)
    for (int n = 0; n < 300; n++) begin
      a9 = rbits(12); b9 = rbits(11);
      step("R6 R7 gaps", 1'b0, ($urandom_range(3) != 0), a9, b9, a9[ME-1:0], b9[ME-1:0]);
    end
    // Start alone, start with a column, amid a high surplus (R4 R5)
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(19));
      a9 = rbits(13); b9 = rbits(13);
      step("R4 R5 start collisions", (r == 0) || (r == 1), (r != 1) && (r != 2),
           a9, b9, a9[ME-1:0], b9[ME-1:0]);
    end
    // Fresh start column with all products zero after a full surplus (R4)
    for (int n = 0; n < 10; n++) step("R4 prefill", 1'b0, 1'b1, '1, '1, '1, '1);
    step("R4 start+valid zero", 1'b1, 1'b1, '1, '0, '1, '0);
    step("R4 idle", 1'b0, 1'b0, '0, '0, '0, '0);
    // Reset mid-stream (R8)
    for (int n = 0; n < 5; n++) step("R8 prefill", 1'b0, 1'b1, '1, '1, '1, '1);
    @(negedge clk);
    check("R8 prefill");
    rst_n = 1'b0; in_valid = 1'b0; start = 1'b0;
    fbc_o = 0; fbc_e = 0; alt_o = 0; alt_e = 0;
    eo_o = 0; ev_o = 0; eo_e = 0; ev_e = 0;
    @(negedge clk);
    check("R8 reset mid-stream");
    rst_n = 1'b1;
    for (int n = 0; n < 50; n++) begin
      a9 = rbits(9); b9 = rbits(9);
      step("R5 R8 after reset", 1'b0, 1'b1, a9, b9, a9[ME-1:0], b9[ME-1:0]);
    end
    step("R6 drain", 1'b0, 1'b0, '0, '0, '0, '0);
    @(negedge clk);
    check("R6 final");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule